// File: doc/BRIEF.md
# USB Endpoint Handshake Engine

This block holds the transaction logic of one endpoint of a low-bandwidth USB function. On one side it sees packet-level events: a decoded token (OUT, IN or SETUP), a received data packet with its PID parity and payload length, and the host's ACK after an IN data packet. On the other side it sees the firmware's control bits. From these it decides whether to send a data packet or a handshake (ACK, NAK or STALL). It also strobes the FIFO read and write enables, keeps the DATA0/DATA1 toggle, records the received byte count and raises the status flags.

Every status flag stays set until firmware pulses the acknowledge input that belongs to it. A write to the flag itself does not clear it. The reported byte count is the payload length plus the two CRC bytes. Serial coding, CRC logic, the transceiver and the FIFO storage belong to neighbouring blocks.

Token codes on `tok_kind`: 0 = OUT, 1 = IN, 2 = SETUP, 3 = ignored. Handshake codes on `hs_code`: 0 = ACK, 1 = NAK, 2 = STALL. `rx_odd` and `tx_odd` are 1 for DATA1 and 0 for DATA0.

Top module: `usb_ep_engine`

## Requirements
- R1: While `cfg_en` is 0, a token produces no data packet, no handshake, no FIFO strobe and no flag change, and neither does a data packet that follows it.
- R2: An IN token while `txrdy` is 0 is answered with a NAK (`hs_code` 1) one cycle after the token.
- R3: An IN token while `txrdy` is 1 asserts `tx_valid` and `fifo_rd` for one cycle, with `tx_odd` equal to `toggle`. A following `host_ack` clears `txrdy`, sets `tx_done` and flips `toggle`. If a new token arrives before `host_ack`, the packet counts as lost and the next IN resends it with the same parity.
- R4: A data packet after an OUT token, of length at most 8, with parity equal to `toggle`, while `rx_out` is 0 and stall is off, is answered with ACK and `fifo_wr`. It sets `rx_out`, flips `toggle` and loads `byte_cnt` with the length plus 2.
- R5: An OUT data packet that arrives while `rx_out` is still 1 gets a NAK. It causes no `fifo_wr` and leaves `byte_cnt` and `toggle` unchanged.
- R6: An OUT data packet whose parity differs from `toggle` is ACKed and discarded: no `fifo_wr`, no flag, and `toggle` and `byte_cnt` stay unchanged.
- R7: On an endpoint with `cfg_ctrl` = 1, a SETUP token followed by a DATA0 packet of 8 bytes is ACKed and written to the FIFO. It sets `rx_setup`, loads `byte_cnt` with 10 and sets `toggle` to 1, even while stall is on or `rx_out` is set. A SETUP on a non-control endpoint, or with DATA1, gets no response.
- R8: While `cfg_stall` is 1, an IN token, and the data packet of an OUT transaction, are answered with STALL (`hs_code` 2). No FIFO strobe occurs and `stall_sent` is set.
- R9: `tx_done`, `rx_out`, `rx_setup` and `stall_sent` clear only on their own acknowledge pulse. A set in the same cycle as the acknowledge wins. `irq` is the OR of the four flags.
- R10: A pulse on `fw_tgl_wr` loads `toggle` with `fw_tgl_val`.
- R11: A data packet with a length above 8 gets no handshake and has no effect on the FIFO, flags, count or toggle.
- R12: A pulse on `fw_de_set` sets `data_end`. An accepted SETUP clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Endpoint enable |
| cfg_ctrl | input | 1 | Endpoint is a control endpoint |
| cfg_stall | input | 1 | Force-stall control bit |
| tok_valid | input | 1 | Token received this cycle |
| tok_kind | input | 2 | Token type (0 OUT, 1 IN, 2 SETUP) |
| rx_valid | input | 1 | Data packet received this cycle |
| rx_odd | input | 1 | Received PID is DATA1 |
| rx_len | input | 4 | Received payload length in bytes |
| host_ack | input | 1 | Host ACK after our data packet |
| fw_txrdy_set | input | 1 | Firmware marks transmit data ready |
| fw_de_set | input | 1 | Firmware sets the data-end bit |
| fw_tgl_wr | input | 1 | Firmware toggle write strobe |
| fw_tgl_val | input | 1 | Value for toggle write |
| fw_ack_txdone | input | 1 | Acknowledge for tx_done |
| fw_ack_rxout | input | 1 | Acknowledge for rx_out |
| fw_ack_setup | input | 1 | Acknowledge for rx_setup |
| fw_ack_stall | input | 1 | Acknowledge for stall_sent |
| hs_valid | output | 1 | Send handshake this cycle |
| hs_code | output | 2 | Handshake type (0 ACK, 1 NAK, 2 STALL) |
| tx_valid | output | 1 | Send data packet this cycle |
| tx_odd | output | 1 | Data packet is DATA1 |
| fifo_wr | output | 1 | Commit received data to FIFO |
| fifo_rd | output | 1 | Read FIFO for transmission |
| txrdy | output | 1 | Transmit data ready flag |
| tx_done | output | 1 | Transmit complete flag |
| rx_out | output | 1 | OUT data received flag |
| rx_setup | output | 1 | SETUP data received flag |
| stall_sent | output | 1 | STALL was sent flag |
| data_end | output | 1 | Last-packet marker |
| toggle | output | 1 | Expected/next data PID parity |
| byte_cnt | output | 4 | Received length including CRC |
| irq | output | 1 | Interrupt request |

## Verification
Every response is registered once. A handshake, a data-packet strobe or a FIFO strobe appears in the cycle right after the token, data packet or host ACK that caused it. The flag, toggle and byte count updates land on the same edge. An acknowledge or firmware pulse shows its effect one cycle later. The bench drives each stimulus for one cycle starting at a falling edge and samples at the next falling edge. This catches the one-cycle handshake pulse and the updated state together. Sweeps cover every legal and illegal length and both parities, with expected toggle, count and flags tracked arithmetically in the bench.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  typedef enum logic [1:0] {TK_OUT = 2'd0, TK_IN = 2'd1, TK_SETUP = 2'd2, TK_RSV = 2'd3} tok_e;
  typedef enum logic [1:0] {HS_ACK = 2'd0, HS_NAK = 2'd1, HS_STALL = 2'd2, HS_NONE = 2'd3} hs_e;
  typedef enum logic [1:0] {PD_IDLE = 2'd0, PD_OUT = 2'd1, PD_SETUP = 2'd2, PD_INWAIT = 2'd3} pend_e;
  localparam int FLAG_TXDONE = 0;
  localparam int FLAG_RXOUT  = 1;
  localparam int FLAG_SETUP  = 2;
  localparam int FLAG_STALL  = 3;
  localparam int NUM_FLAGS   = 4;
endpackage

// File: rtl/usb_ep_xact.sv
module usb_ep_xact
  import usb_ep_pkg::*;
#(
  parameter int MAX_LEN   = 8,
  parameter int SETUP_LEN = 8,
  parameter int LW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          ctrl_ep,
  input  logic          stall,
  input  logic          txrdy,
  input  logic          rx_busy,
  input  logic          tgl,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          rx_valid,
  input  logic          rx_odd,
  input  logic [LW-1:0] rx_len,
  input  logic          host_ack,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic          tx_valid,
  output logic          tx_odd,
  output logic          fifo_wr,
  output logic          fifo_rd,
  output logic          ev_in_done,
  output logic          ev_out_ok,
  output logic          ev_setup_ok,
  output logic          ev_stall
);
  function automatic logic len_ok(input logic [LW-1:0] l);
    return l <= LW'(MAX_LEN);
  endfunction

  pend_e pend_q, pend_n;
  hs_e   hs_n;
  logic  tx_n, wr_n, rd_n;

  always_comb begin
    pend_n = pend_q;
    hs_n = HS_NONE;
    tx_n = 1'b0;
    wr_n = 1'b0;
    rd_n = 1'b0;
    ev_in_done = 1'b0;
    ev_out_ok = 1'b0;
    ev_setup_ok = 1'b0;
    ev_stall = 1'b0;
    if (tok_valid) begin
      pend_n = PD_IDLE;
      if (en) begin
        case (tok_e'(tok_kind))
          TK_IN: begin
            if (stall) begin
              hs_n = HS_STALL;
              ev_stall = 1'b1;
            end else if (!txrdy) begin
              hs_n = HS_NAK;
            end else begin
              tx_n = 1'b1;
              rd_n = 1'b1;
              pend_n = PD_INWAIT;
            end
          end
          TK_OUT:   pend_n = PD_OUT;
          TK_SETUP: if (ctrl_ep) pend_n = PD_SETUP;
          default:  pend_n = PD_IDLE;
        endcase
      end
    end else if (rx_valid) begin
      pend_n = PD_IDLE;
      if (len_ok(rx_len)) begin
        if (pend_q == PD_SETUP) begin
          if (!rx_odd && rx_len == LW'(SETUP_LEN)) begin
            hs_n = HS_ACK;
            wr_n = 1'b1;
            ev_setup_ok = 1'b1;
          end
        end else if (pend_q == PD_OUT) begin
          if (stall) begin
            hs_n = HS_STALL;
            ev_stall = 1'b1;
          end else if (rx_busy) begin
            hs_n = HS_NAK;
          end else if (rx_odd != tgl) begin
            hs_n = HS_ACK;
          end else begin
            hs_n = HS_ACK;
            wr_n = 1'b1;
            ev_out_ok = 1'b1;
          end
        end
      end
    end else if (host_ack && pend_q == PD_INWAIT) begin
      ev_in_done = 1'b1;
      pend_n = PD_IDLE;
    end
  end

  hs_e hs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PD_IDLE;
      hs_q <= HS_NONE;
      tx_valid <= 1'b0;
      tx_odd <= 1'b0;
      fifo_wr <= 1'b0;
      fifo_rd <= 1'b0;
    end else begin
      pend_q <= pend_n;
      hs_q <= hs_n;
      tx_valid <= tx_n;
      tx_odd <= tgl;
      fifo_wr <= wr_n;
      fifo_rd <= rd_n;
    end
  end

  assign hs_valid = (hs_q != HS_NONE);
  assign hs_code  = hs_q;

  // R1: a token on a disabled endpoint draws no response
  p_quiet_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !en) |=> (!hs_valid && !tx_valid && !fifo_rd));

  // R5: busy receive buffer forces NAK and blocks the write
  p_nak_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !tok_valid && pend_q == PD_OUT && !stall && rx_busy && len_ok(rx_len))
      |=> (hs_valid && hs_code == HS_NAK && !fifo_wr));

  // R3: a data packet and a handshake never go out together
  p_one_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_valid, tx_valid}));
endmodule

// File: rtl/usb_ep_flags.sv
module usb_ep_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R9: acknowledge clears the flag unless a new event sets it
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);
    // R9: nothing but the acknowledge clears a flag
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q[i] && !clr[i]) |=> q[i]);
  end
endmodule

// File: rtl/usb_ep_toggle.sv
module usb_ep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  input  logic force_one,
  input  logic wr,
  input  logic wr_val,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= 1'b0;
    else if (force_one) q <= 1'b1;
    else if (flip)      q <= ~q;
    else if (wr)        q <= wr_val;
  end

  // R4: a completed transaction moves to the other parity
  p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !force_one) |=> (q != $past(q)));
  // R6: with no event or write the parity holds
  p_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip && !force_one && !wr) |=> $stable(q));
endmodule

// File: rtl/usb_ep_engine.sv
module usb_ep_engine
  import usb_ep_pkg::*;
#(
  parameter int MAX_LEN = 8,
  parameter int CRC_LEN = 2,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int CW = $clog2(MAX_LEN + CRC_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          cfg_ctrl,
  input  logic          cfg_stall,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          rx_valid,
  input  logic          rx_odd,
  input  logic [LW-1:0] rx_len,
  input  logic          host_ack,
  input  logic          fw_txrdy_set,
  input  logic          fw_de_set,
  input  logic          fw_tgl_wr,
  input  logic          fw_tgl_val,
  input  logic          fw_ack_txdone,
  input  logic          fw_ack_rxout,
  input  logic          fw_ack_setup,
  input  logic          fw_ack_stall,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic          tx_valid,
  output logic          tx_odd,
  output logic          fifo_wr,
  output logic          fifo_rd,
  output logic          txrdy,
  output logic          tx_done,
  output logic          rx_out,
  output logic          rx_setup,
  output logic          stall_sent,
  output logic          data_end,
  output logic          toggle,
  output logic [CW-1:0] byte_cnt,
  output logic          irq
);
  function automatic logic [CW-1:0] wire_count(input logic [LW-1:0] len);
    return CW'(len) + CW'(CRC_LEN);
  endfunction

  logic ev_in_done, ev_out_ok, ev_setup_ok, ev_stall;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

  usb_ep_xact #(.MAX_LEN(MAX_LEN), .SETUP_LEN(8), .LW(LW)) u_xact (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .ctrl_ep(cfg_ctrl), .stall(cfg_stall),
    .txrdy(txrdy), .rx_busy(rx_out), .tgl(toggle),
    .tok_valid(tok_valid), .tok_kind(tok_kind), .rx_valid(rx_valid), .rx_odd(rx_odd),
    .rx_len(rx_len), .host_ack(host_ack),
    .hs_valid(hs_valid), .hs_code(hs_code), .tx_valid(tx_valid), .tx_odd(tx_odd),
    .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .ev_in_done(ev_in_done), .ev_out_ok(ev_out_ok), .ev_setup_ok(ev_setup_ok),
    .ev_stall(ev_stall)
  );

  always_comb begin
    flag_set = '0;
    flag_clr = '0;
    flag_set[FLAG_TXDONE] = ev_in_done;
    flag_set[FLAG_RXOUT]  = ev_out_ok;
    flag_set[FLAG_SETUP]  = ev_setup_ok;
    flag_set[FLAG_STALL]  = ev_stall;
    flag_clr[FLAG_TXDONE] = fw_ack_txdone;
    flag_clr[FLAG_RXOUT]  = fw_ack_rxout;
    flag_clr[FLAG_SETUP]  = fw_ack_setup;
    flag_clr[FLAG_STALL]  = fw_ack_stall;
  end

  usb_ep_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .q(flag_q)
  );

  assign tx_done    = flag_q[FLAG_TXDONE];
  assign rx_out     = flag_q[FLAG_RXOUT];
  assign rx_setup   = flag_q[FLAG_SETUP];
  assign stall_sent = flag_q[FLAG_STALL];
  assign irq        = |flag_q;

  usb_ep_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .flip(ev_in_done | ev_out_ok), .force_one(ev_setup_ok),
    .wr(fw_tgl_wr), .wr_val(fw_tgl_val), .q(toggle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txrdy <= 1'b0;
      data_end <= 1'b0;
      byte_cnt <= '0;
    end else begin
      if (ev_in_done)        txrdy <= 1'b0;
      else if (fw_txrdy_set) txrdy <= 1'b1;
      if (ev_setup_ok)       data_end <= 1'b0;
      else if (fw_de_set)    data_end <= 1'b1;
      if (ev_out_ok || ev_setup_ok) byte_cnt <= wire_count(rx_len);
    end
  end

  // R4: the recorded count never exceeds payload limit plus CRC
  p_bcnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CW'(MAX_LEN + CRC_LEN));
  // R3: an acknowledged IN clears the ready flag
  p_txrdy_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in_done |=> !txrdy);
endmodule

// File: tb/usb_ep_engine_tb.sv
module usb_ep_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b1, cfg_ctrl = 1'b0, cfg_stall = 1'b0;
  logic tok_valid = 1'b0;
  logic [1:0] tok_kind = 2'd0;
  logic rx_valid = 1'b0, rx_odd = 1'b0;
  logic [3:0] rx_len = 4'd0;
  logic host_ack = 1'b0, fw_txrdy_set = 1'b0, fw_de_set = 1'b0;
  logic fw_tgl_wr = 1'b0, fw_tgl_val = 1'b0;
  logic fw_ack_txdone = 1'b0, fw_ack_rxout = 1'b0, fw_ack_setup = 1'b0, fw_ack_stall = 1'b0;
  logic hs_valid, tx_valid, tx_odd, fifo_wr, fifo_rd, txrdy, tx_done, rx_out;
  logic rx_setup, stall_sent, data_end, toggle, irq;
  logic [1:0] hs_code;
  logic [3:0] byte_cnt;

  int nchk = 0, nerr = 0;
  logic texp;
  logic [3:0] cexp;

  always #5 clk = ~clk;

  usb_ep_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_ctrl(cfg_ctrl), .cfg_stall(cfg_stall),
    .tok_valid(tok_valid), .tok_kind(tok_kind), .rx_valid(rx_valid), .rx_odd(rx_odd),
    .rx_len(rx_len), .host_ack(host_ack), .fw_txrdy_set(fw_txrdy_set), .fw_de_set(fw_de_set),
    .fw_tgl_wr(fw_tgl_wr), .fw_tgl_val(fw_tgl_val), .fw_ack_txdone(fw_ack_txdone),
    .fw_ack_rxout(fw_ack_rxout), .fw_ack_setup(fw_ack_setup), .fw_ack_stall(fw_ack_stall),
    .hs_valid(hs_valid), .hs_code(hs_code), .tx_valid(tx_valid), .tx_odd(tx_odd),
    .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .txrdy(txrdy), .tx_done(tx_done), .rx_out(rx_out),
    .rx_setup(rx_setup), .stall_sent(stall_sent), .data_end(data_end), .toggle(toggle),
    .byte_cnt(byte_cnt), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send_tok(input logic [1:0] k);
    tok_valid = 1'b1; tok_kind = k;
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic send_dat(input logic odd, input int len);
    rx_valid = 1'b1; rx_odd = odd; rx_len = 4'(len);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic ack(input logic [3:0] m);
    {fw_ack_stall, fw_ack_setup, fw_ack_rxout, fw_ack_txdone} = m;
    @(negedge clk);
    {fw_ack_stall, fw_ack_setup, fw_ack_rxout, fw_ack_txdone} = 4'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    nchk++; nerr++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset flags", {tx_done, rx_out, rx_setup, stall_sent, txrdy, data_end}, 0);
    check("reset toggle/count", {toggle, byte_cnt}, 0);
    check("reset outputs", {hs_valid, tx_valid, fifo_wr, fifo_rd, irq}, 0);
    texp = 1'b0; cexp = 4'd0;

    // R2: IN with nothing ready
    send_tok(2'd1);
    check("R2 nak valid", hs_valid, 1);
    check("R2 nak code", hs_code, 1);
    check("R2 no data", tx_valid, 0);

    // R1: disabled endpoint
    cfg_en = 1'b0;
    send_tok(2'd1);
    check("R1 IN silent", {hs_valid, tx_valid, fifo_rd}, 0);
    send_tok(2'd0);
    send_dat(texp, 4);
    check("R1 OUT silent", {hs_valid, fifo_wr, rx_out, toggle}, 0);
    cfg_en = 1'b1;

    // R4/R5/R9: sweep every legal length
    for (int len = 0; len <= 8; len++) begin
      send_tok(2'd0);
      check("R4 pending no hs", hs_valid, 0);
      send_dat(texp, len);
      check("R4 ack", {hs_valid, hs_code}, 4);
      check("R4 write", fifo_wr, 1);
      check("R4 rx_out", rx_out, 1);
      check("R4 count", byte_cnt, len + 2);
      check("R4 toggle", toggle, !texp);
      check("R9 irq", irq, 1);
      texp = !texp; cexp = 4'(len + 2);
      send_tok(2'd0);
      send_dat(texp, (len + 3) % 9);
      check("R5 nak", {hs_valid, hs_code}, 5);
      check("R5 no write", fifo_wr, 0);
      check("R5 count kept", byte_cnt, cexp);
      check("R5 toggle kept", toggle, texp);
      ack(4'b0010);
      check("R9 rx_out cleared", rx_out, 0);
      check("R9 irq low", irq, 0);
    end

    // R6: wrong parity
    for (int len = 0; len <= 8; len += 4) begin
      send_tok(2'd0);
      send_dat(!texp, len);
      check("R6 ack", {hs_valid, hs_code}, 4);
      check("R6 discard", {fifo_wr, rx_out}, 0);
      check("R6 toggle", toggle, texp);
      check("R6 count", byte_cnt, cexp);
    end

    // R11: oversize packets
    for (int len = 9; len <= 15; len++) begin
      send_tok(2'd0);
      send_dat(texp, len);
      check("R11 no hs", {hs_valid, fifo_wr, rx_out}, 0);
      check("R11 state", {toggle, byte_cnt}, {texp, cexp});
    end

    // R3: IN data path, both parities, with one lost packet
    for (int k = 0; k < 2; k++) begin
      fw_txrdy_set = 1'b1; @(negedge clk); fw_txrdy_set = 1'b0;
      check("R3 txrdy set", txrdy, 1);
      send_tok(2'd1);
      check("R3 data", {tx_valid, fifo_rd, hs_valid}, 6);
      check("R3 pid", tx_odd, texp);
      send_tok(2'd1);
      check("R3 resend pid", {tx_valid, tx_odd}, {1'b1, texp});
      check("R3 still ready", {txrdy, tx_done}, 2);
      host_ack = 1'b1; @(negedge clk); host_ack = 1'b0;
      check("R3 done", {txrdy, tx_done, irq}, 3);
      check("R3 toggle", toggle, !texp);
      texp = !texp;
      ack(4'b0001);
      check("R9 tx_done cleared", tx_done, 0);
    end

    // R10: firmware toggle write
    fw_tgl_wr = 1'b1; fw_tgl_val = 1'b1; @(negedge clk); fw_tgl_wr = 1'b0;
    check("R10 write 1", toggle, 1);
    fw_tgl_wr = 1'b1; fw_tgl_val = 1'b0; @(negedge clk); fw_tgl_wr = 1'b0;
    check("R10 write 0", toggle, 0);
    texp = 1'b0;

    // R12: data_end set
    fw_de_set = 1'b1; @(negedge clk); fw_de_set = 1'b0;
    check("R12 set", data_end, 1);

    // R7: setup on non-control endpoint ignored
    send_tok(2'd2);
    send_dat(1'b0, 8);
    check("R7 non-ctrl ignored", {hs_valid, fifo_wr, rx_setup}, 0);
    cfg_ctrl = 1'b1;
    send_tok(2'd2);
    send_dat(1'b1, 8);
    check("R7 DATA1 ignored", {hs_valid, fifo_wr, rx_setup}, 0);
    send_tok(2'd0);
    send_dat(texp, 3);
    texp = !texp;
    check("R7 rx_out pre", rx_out, 1);
    cfg_stall = 1'b1;
    send_tok(2'd2);
    send_dat(1'b0, 8);
    check("R7 ack", {hs_valid, hs_code, fifo_wr}, 9);
    check("R7 flag", rx_setup, 1);
    check("R7 count", byte_cnt, 10);
    check("R7 toggle", toggle, 1);
    check("R12 cleared", data_end, 0);
    ack(4'b0110);
    check("R9 setup cleared", {rx_setup, rx_out}, 0);

    // R8: stall
    send_tok(2'd1);
    check("R8 IN stall", {hs_valid, hs_code, tx_valid, fifo_rd}, 6 << 2);
    check("R8 flag", stall_sent, 1);
    ack(4'b1000);
    check("R9 stall cleared", stall_sent, 0);
    send_tok(2'd0);
    check("R8 OUT pending", hs_valid, 0);
    send_dat(1'b1, 2);
    check("R8 OUT stall", {hs_valid, hs_code, fifo_wr}, 12);
    check("R8 OUT flags", {stall_sent, rx_out}, 2);
    // R9: set in the cycle of its acknowledge wins
    tok_valid = 1'b1; tok_kind = 2'd1; fw_ack_stall = 1'b1;
    @(negedge clk);
    tok_valid = 1'b0; fw_ack_stall = 1'b0;
    check("R9 set wins", stall_sent, 1);
    ack(4'b1000);
    check("R9 final clear", {stall_sent, irq}, 0);
    cfg_stall = 1'b0;

    finish_run();
  end
endmodule